// File: doc/BRIEF.md
# Dual-Channel PWM Timer with Up/Down and Single-Slope Counting

This block derives two pulse-width-modulated outputs, A and B, from one shared counter and two compare values. The counter width in use is picked at run time as 8, 9 or 10 bits. In the default dual-slope mode the counter climbs from zero to its end value and then descends back to zero, so both pulses are centred on the counter's low point. A single-slope mode makes the counter climb and wrap, which doubles the output frequency.

Each channel has a 2-bit output-mode field that chooses non-inverting, inverting or disconnected output. Compare values arrive on plain input ports and are held in a staging path. They reach the comparator only when the counter sits at its end value, so a value written in mid-period can never cut a pulse short. Bus access, clock prescaling and interrupts sit outside this block.

Top module: `pwm_dual_timer`

## Requirements
- R1: While `rst_n` is low, `count` is 0, `count_up` is 1, both active compare values are 0, and `pwm_a`/`pwm_b` are low for output modes 10 and 00.
- R2: The end value TOP is 255 for `res_sel`=00, 511 for 01, and 1023 for 10 and 11.
- R3: With `fast_mode`=0 the count moves by exactly one per clock: 0 up to TOP, then down to 0, repeating with a period of 2*TOP cycles. `count_up` reads 1 at 0 and while rising, and 0 at TOP and while falling.
- R4: With `fast_mode`=1 the count runs 0..TOP and then returns to 0, with a period of TOP+1 cycles, and `count_up` stays 1.
- R5: Only the low 8, 9 or 10 bits of each 16-bit compare input, as chosen by `res_sel`, take part in matching. The upper bits are discarded.
- R6: With `fast_mode`=0 and mode 10, the level goes low when the count equals the compare value C while rising, and high when it equals C while falling. The pin changes in the cycle after `count` shows C, and it is high for 2*C cycles per period.
- R7: Mode 11 drives the exact complement of what mode 10 would drive for the same compare value.
- R8: Modes 00 and 01 hold the pin low.
- R9: A new compare input is copied to the active compare register only on the clock edge at which the count equals TOP. Before that edge, matching uses the previous value.
- R10: With `fast_mode`=1 and mode 10, the pin goes high in the cycle when the count shows 0 and goes low in the cycle after the count shows C. It is high for C+1 cycles per period.
- R11: A compare value of 0 gives a constant low level and a value of TOP gives a constant high level (mode 10), in both counting modes.
- R12: Channels A and B use separate compare values and modes and do not affect each other.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| res_sel | input | 2 | Resolution: 00=8, 01=9, 10/11=10 bits |
| fast_mode | input | 1 | 1 = single-slope double-speed counting |
| cmp_a | input | 16 | Compare value input, channel A |
| cmp_b | input | 16 | Compare value input, channel B |
| mode_a | input | 2 | Output mode, channel A (00/01 off, 10 normal, 11 inverted) |
| mode_b | input | 2 | Output mode, channel B |
| pwm_a | output | 1 | PWM output A |
| pwm_b | output | 1 | PWM output B |
| count | output | 10 | Current counter value |
| count_up | output | 1 | Direction flag of the current count |

## Verification
A match has one register stage between it and the pins: when `count` shows the compare value after a rising edge, the pin reflects the match after the next rising edge. The bench samples on falling edges, so it expects the new level at the sample that follows the one where `count` showed the value. A changed compare input takes effect only after the next TOP, and after a mode or resolution change the counter may need most of a long period to come back into range. For these reasons each table row first waits three of the longest periods before it counts high cycles over exactly one period. The directed tests use `count` and `count_up` as the time reference and check the level at the exact samples that R6, R9 and R10 name.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;

  localparam int BASE_RES = 8;
  localparam int MAX_RES  = 10;
  localparam int CNT_W    = MAX_RES;
  localparam int NUM_CH   = 2;

  typedef logic [CNT_W-1:0] cnt_t;

  typedef enum logic [1:0] {
    OUT_OFF    = 2'b00,
    OUT_RSVD   = 2'b01,
    OUT_NORMAL = 2'b10,
    OUT_INVERT = 2'b11
  } out_mode_e;

  // End value of the count for a resolution code; codes past the widest clip to it.
  function automatic cnt_t top_for_res(input logic [1:0] res);
    int unsigned bits;
    bits = BASE_RES + int'(res);
    if (bits > MAX_RES) bits = MAX_RES;
    return cnt_t'((32'd1 << bits) - 32'd1);
  endfunction

  // Pin level for a raw (non-inverted) waveform level under an output mode.
  function automatic logic pin_level(input out_mode_e mode, input logic lvl);
    case (mode)
      OUT_NORMAL: return lvl;
      OUT_INVERT: return ~lvl;
      default:    return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/pwm_slope_counter.sv
module pwm_slope_counter
  import pwm_timer_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic fast,
  input  cnt_t top,
  output cnt_t cnt,
  output logic up,
  output logic at_top
);

  cnt_t cnt_nxt;
  logic up_nxt;

  always_comb begin
    cnt_nxt = cnt;
    up_nxt  = up;
    if (fast) begin
      up_nxt  = 1'b1;
      cnt_nxt = (cnt >= top) ? '0 : cnt + 1'b1;
    end else if (up) begin
      if (cnt >= top) begin
        cnt_nxt = cnt - 1'b1;
        up_nxt  = 1'b0;
      end else if (cnt == top - 1'b1) begin
        cnt_nxt = top;
        up_nxt  = 1'b0;
      end else begin
        cnt_nxt = cnt + 1'b1;
      end
    end else begin
      if (cnt == '0) begin
        cnt_nxt = cnt + 1'b1;
        up_nxt  = 1'b1;
      end else if (cnt == cnt_t'(1)) begin
        cnt_nxt = '0;
        up_nxt  = 1'b1;
      end else begin
        cnt_nxt = cnt - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      up  <= 1'b1;
    end else begin
      cnt <= cnt_nxt;
      up  <= up_nxt;
    end
  end

  assign at_top = (cnt == top);

  AST_DUAL_SLOPE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(fast)) |->
      ((cnt == $past(cnt) + 1'b1) || (cnt == $past(cnt) - 1'b1))); // R3

  AST_TOP_TURNS_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(fast) && ($past(cnt) == $past(top))) |-> !up); // R3

  AST_SINGLE_SLOPE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(fast) && ($past(cnt) >= $past(top))) |-> (cnt == '0)); // R4

  AST_SINGLE_SLOPE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(fast)) |-> (up && (cnt <= $past(top)))); // R4

endmodule

// File: rtl/pwm_out_channel.sv
module pwm_out_channel
  import pwm_timer_pkg::*;
#(
  parameter int CMP_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fast,
  input  cnt_t             cnt,
  input  logic             up,
  input  logic             at_top,
  input  cnt_t             top,
  input  logic [CMP_W-1:0] cmp_in,
  input  logic [1:0]       mode,
  output logic             pwm
);

  cnt_t active_cmp;
  cnt_t staged_cmp;
  logic lvl;
  logic match;

  // Only the resolution bits survive; TOP doubles as the mask.
  assign staged_cmp = cnt_t'(cmp_in & CMP_W'(top));
  assign match      = (cnt == active_cmp);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) active_cmp <= '0;
    else if (at_top) active_cmp <= staged_cmp;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl <= 1'b0;
    end else if (fast) begin
      if (at_top) lvl <= (staged_cmp != '0);
      else if (match) lvl <= 1'b0;
    end else if (match) begin
      lvl <= ~up;
    end
  end

  assign pwm = pin_level(out_mode_e'(mode), lvl);

  AST_LOAD_ONLY_AT_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(at_top)) |-> (active_cmp == $past(active_cmp))); // R9

  AST_DUAL_RISE_ON_FALLING: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(fast) && $rose(lvl)) |-> (!$past(up) && $past(match))); // R6

  AST_DUAL_FALL_ON_RISING: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(fast) && $fell(lvl)) |-> ($past(up) && $past(match))); // R6

  AST_SINGLE_FALL_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(fast) && $fell(lvl)) |-> ($past(match) || $past(at_top))); // R10

endmodule

// File: rtl/pwm_dual_timer.sv
module pwm_dual_timer
  import pwm_timer_pkg::*;
#(
  parameter int CMP_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       res_sel,
  input  logic             fast_mode,
  input  logic [CMP_W-1:0] cmp_a,
  input  logic [CMP_W-1:0] cmp_b,
  input  logic [1:0]       mode_a,
  input  logic [1:0]       mode_b,
  output logic             pwm_a,
  output logic             pwm_b,
  output logic [CNT_W-1:0] count,
  output logic             count_up
);

  cnt_t top;
  cnt_t cnt;
  logic up;
  logic at_top;

  logic [CMP_W-1:0] cmp_arr  [NUM_CH];
  logic [1:0]       mode_arr [NUM_CH];
  logic             pwm_arr  [NUM_CH];

  assign top = top_for_res(res_sel);

  assign cmp_arr[0]  = cmp_a;
  assign cmp_arr[1]  = cmp_b;
  assign mode_arr[0] = mode_a;
  assign mode_arr[1] = mode_b;

  pwm_slope_counter u_counter (
    .clk    (clk),
    .rst_n  (rst_n),
    .fast   (fast_mode),
    .top    (top),
    .cnt    (cnt),
    .up     (up),
    .at_top (at_top)
  );

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    pwm_out_channel #(.CMP_W(CMP_W)) u_chan (
      .clk    (clk),
      .rst_n  (rst_n),
      .fast   (fast_mode),
      .cnt    (cnt),
      .up     (up),
      .at_top (at_top),
      .top    (top),
      .cmp_in (cmp_arr[ch]),
      .mode   (mode_arr[ch]),
      .pwm    (pwm_arr[ch])
    );
  end

  assign pwm_a    = pwm_arr[0];
  assign pwm_b    = pwm_arr[1];
  assign count    = cnt;
  assign count_up = up;

endmodule

// File: tb/pwm_dual_timer_bench.sv
module pwm_dual_timer_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  res_sel = 2'b00;
  logic        fast_mode = 1'b0;
  logic [15:0] cmp_a = '0;
  logic [15:0] cmp_b = '0;
  logic [1:0]  mode_a = 2'b10;
  logic [1:0]  mode_b = 2'b10;
  logic        pwm_a, pwm_b, count_up;
  logic [9:0]  count;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  pwm_dual_timer u_pwm_dual_timer (
    .clk(clk), .rst_n(rst_n), .res_sel(res_sel), .fast_mode(fast_mode),
    .cmp_a(cmp_a), .cmp_b(cmp_b), .mode_a(mode_a), .mode_b(mode_b),
    .pwm_a(pwm_a), .pwm_b(pwm_b), .count(count), .count_up(count_up)
  );

  typedef struct packed {
    logic        fast;
    logic [1:0]  res;
    logic [15:0] ca;
    logic [1:0]  ma;
    logic [15:0] cb;
    logic [1:0]  mb;
    logic [11:0] hi_a;
    logic [11:0] hi_b;
  } vec_t;

  // Expected high cycles per period, worked out from R6, R7, R8, R10, R11.
  localparam vec_t VECS [8] = '{
    '{1'b0, 2'd0, 16'd100,   2'b10, 16'd50,    2'b11, 12'd200,  12'd410},  // R6 R7 R12
    '{1'b0, 2'd0, 16'd0,     2'b10, 16'd255,   2'b10, 12'd0,    12'd510},  // R11
    '{1'b0, 2'd0, 16'h0164,  2'b10, 16'd20,    2'b00, 12'd200,  12'd0},    // R5 R8
    '{1'b1, 2'd0, 16'd100,   2'b10, 16'd100,   2'b11, 12'd101,  12'd155},  // R10 R7
    '{1'b1, 2'd0, 16'd0,     2'b10, 16'd255,   2'b10, 12'd0,    12'd256},  // R11
    '{1'b0, 2'd1, 16'd300,   2'b10, 16'h0300,  2'b10, 12'd600,  12'd512},  // R2 R5
    '{1'b1, 2'd2, 16'd1023,  2'b11, 16'd500,   2'b01, 12'd0,    12'd0},    // R11 R8
    '{1'b0, 2'd3, 16'd1000,  2'b10, 16'd1,     2'b10, 12'd2000, 12'd2}     // R2
  };

  function automatic int exp_top(input logic [1:0] r);
    case (r)
      2'd0:    return 255;
      2'd1:    return 511;
      default: return 1023;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic wait_count(input int val, input bit dir);
    do @(negedge clk); while (!(count == 10'(val) && count_up == dir));
  endtask

  // From a sample at count 0 (rising), walk one full period.
  task automatic walk_period(output int len, output int maxv, output int bad, output int up_at_max);
    int prev;
    wait_count(0, 1'b1);
    len = 0; maxv = 0; bad = 0; up_at_max = 0;
    prev = 0;
    do begin
      @(negedge clk);
      len++;
      if (!fast_mode && (int'(count) != prev + 1) && (int'(count) != prev - 1)) bad++;
      if (fast_mode && !count_up) bad++;
      if (int'(count) > maxv) begin
        maxv = int'(count);
        up_at_max = int'(count_up);
      end
      prev = int'(count);
    end while (count != 10'd0);
  endtask

  task automatic count_high(input int per, output int ha, output int hb);
    ha = 0; hb = 0;
    for (int i = 0; i < per; i++) begin
      @(negedge clk);
      ha += int'(pwm_a);
      hb += int'(pwm_b);
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 190000) begin
        check(1'b0, "watchdog", cycles, 190000);
        finish_run();
      end
    end
  end

  initial begin
    int len, maxv, bad, upm, ha, hb, per;

    // R1: reset state
    repeat (3) @(negedge clk);
    check(count == 10'd0, "R1 count", int'(count), 0);
    check(count_up == 1'b1, "R1 count_up", int'(count_up), 1);
    check(pwm_a == 1'b0 && pwm_b == 1'b0, "R1 pwm", int'({pwm_a, pwm_b}), 0);
    rst_n = 1'b1;

    // R3: dual-slope sequence at 8 bits
    walk_period(len, maxv, bad, upm);
    check(len == 510, "R3 period", len, 510);
    check(maxv == 255, "R3 peak", maxv, 255);
    check(bad == 0, "R3 unit steps", bad, 0);
    check(upm == 0, "R3 count_up at TOP", upm, 0);

    // R4 and R2: single-slope at 8, 9 and 10 bits
    fast_mode = 1'b1;
    for (int r = 0; r < 3; r++) begin
      res_sel = 2'(r);
      repeat (2100) @(negedge clk);
      walk_period(len, maxv, bad, upm);
      check(len == exp_top(2'(r)) + 1, "R4 R2 period", len, exp_top(2'(r)) + 1);
      check(maxv == exp_top(2'(r)), "R2 TOP", maxv, exp_top(2'(r)));
      check(bad == 0, "R4 count_up held", bad, 0);
    end

    // Table: duty per period for both channels
    foreach (VECS[i]) begin
      fast_mode = VECS[i].fast;
      res_sel   = VECS[i].res;
      cmp_a     = VECS[i].ca;
      mode_a    = VECS[i].ma;
      cmp_b     = VECS[i].cb;
      mode_b    = VECS[i].mb;
      repeat (6150) @(negedge clk);
      per = VECS[i].fast ? exp_top(VECS[i].res) + 1 : 2 * exp_top(VECS[i].res);
      count_high(per, ha, hb);
      check(ha == int'(VECS[i].hi_a), "R6 R7 R10 R11 R12 table A", ha, int'(VECS[i].hi_a));
      check(hb == int'(VECS[i].hi_b), "R5 R8 R11 R12 table B", hb, int'(VECS[i].hi_b));
    end

    // R6: exact edge timing in dual-slope mode
    fast_mode = 1'b0; res_sel = 2'd0;
    cmp_a = 16'd100; mode_a = 2'b10; cmp_b = 16'd0; mode_b = 2'b00;
    repeat (2100) @(negedge clk);
    wait_count(100, 1'b1);
    check(pwm_a == 1'b1, "R6 high before rising match", int'(pwm_a), 1);
    @(negedge clk);
    check(pwm_a == 1'b0, "R6 low after rising match", int'(pwm_a), 0);
    wait_count(100, 1'b0);
    check(pwm_a == 1'b0, "R6 low before falling match", int'(pwm_a), 0);
    @(negedge clk);
    check(pwm_a == 1'b1, "R6 high after falling match", int'(pwm_a), 1);

    // R9: compare changed mid-period takes effect only after TOP
    wait_count(20, 1'b1);
    cmp_a = 16'd10;
    wait_count(50, 1'b1);
    check(pwm_a == 1'b1, "R9 old value still active", int'(pwm_a), 1);
    wait_count(50, 1'b0);
    check(pwm_a == 1'b0, "R9 new value after TOP", int'(pwm_a), 0);
    wait_count(9, 1'b0);
    check(pwm_a == 1'b1, "R9 set at new value", int'(pwm_a), 1);

    // R10: exact edge timing in single-slope mode
    fast_mode = 1'b1; cmp_a = 16'd100;
    repeat (2100) @(negedge clk);
    wait_count(100, 1'b1);
    check(pwm_a == 1'b1, "R10 high at match count", int'(pwm_a), 1);
    @(negedge clk);
    check(pwm_a == 1'b0, "R10 low after match", int'(pwm_a), 0);
    wait_count(255, 1'b1);
    check(pwm_a == 1'b0, "R10 low at TOP", int'(pwm_a), 0);
    @(negedge clk);
    check(pwm_a == 1'b1 && count == 10'd0, "R10 high at zero", int'(pwm_a), 1);

    // R1: reset asserted mid-run
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check(count == 10'd0 && count_up == 1'b1, "R1 reset mid-run", int'(count), 0);
    check(pwm_a == 1'b0, "R1 pwm after reset", int'(pwm_a), 0);

    finish_run();
  end

endmodule